// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Port

This block is a byte-wide synchronous serial master that moves eight bits at a time over a single bidirectional data pin and drives its own serial clock. Software sets it up through three registers on a small read/write bus: a control register (clock polarity, clock phase, a 2-bit rate field, a receive request bit and a port enable), a data register, and a status register. Writing the data register while the port is enabled and idle sends that byte, most significant bit first, with the data pin driven only during the send. Setting the receive request bit starts a receive. The request waits while the port is busy or while an earlier received byte has not yet been read. Hardware clears the request after the eighth bit.

The sequencing is a three-state machine. `ST_IDLE` holds the clock at its idle level and leaves the data pin undriven. `ST_IDLE -> ST_TX` is taken on an accepted data write. `ST_IDLE -> ST_RX` is taken on a pending receive request with an empty buffer. Both `ST_TX -> ST_IDLE` and `ST_RX -> ST_IDLE` are taken at the end of the sixteenth clock half-period, and this raises the sticky completion flag. Two more sticky flags record accesses to the data register that collide with a transfer: a write during a send, and a read during a receive. Software clears each flag by writing 1 to it.

Top module: `hdx_serial_port`

## Requirements
- R1: After reset the control and status registers read 0, the serial clock is low, and the data pin output and its enable are low.
- R2: Register map, selected by `reg_addr`. Address 0 is control: bit0 clock polarity, bit1 clock phase, bits3:2 rate, bit4 receive request, bit5 port enable. Address 1 is data. Address 2 is status: bit0 done, bit1 write collision, bit2 read collision, bit3 busy, bit4 receive buffer full. Address 3 reads 0. Control reads back as written.
- R3: While idle the serial clock equals the polarity bit. In half-period h (0 to 15) of a transfer it equals polarity XOR phase XOR (h mod 2). With phase 0, data is therefore set up before the first edge of each bit. With phase 1, data is launched on the first edge.
- R4: Each half-period lasts 2<<rate system clocks (4, 8, 16 or 32 clocks per serial clock), so a transfer lasts 32<<rate clocks.
- R5: A data write that is accepted starts a send on that same clock edge. Bit 7-b of the byte is driven during half-periods 2b and 2b+1, and the output enable is high only during a send.
- R6: A receive starts one clock after the request bit is seen while the port is enabled, idle and the buffer is empty. Otherwise the request stays pending. The data pin is sampled at the end of half-period 2b into bit 7-b. After the eighth bit the request bit clears, the buffer-full flag sets, and the byte reads from the data register.
- R7: Reading the data register while no receive is running clears the buffer-full flag.
- R8: The end of a send or a receive sets the done flag. The flag stays set until software clears it.
- R9: A data write during a send sets the write-collision flag and does not change the byte being sent.
- R10: A data read during a receive sets the read-collision flag.
- R11: With the port enable at 0, a data write starts nothing.
- R12: Writing 1 to status bit 0, 1 or 2 clears only that flag. Writing 0, or writing the busy or full bits, has no effect. A flag being set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on data reads) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data out |
| sdata_oe | output | 1 | Data pin output enable |
| sdata_i | input | 1 | Serial data in from the shared pin |

## Verification
A wrong state or a wrong half-period count shows up at once on `sclk_o`: within one half-period the level differs from polarity XOR phase XOR h. The bench samples the first and the last clock of every half-period. A slip in the bit counter ends the transfer early or late, so the done flag and the return of the clock to idle appear at the wrong cycle. A receive that shifts wrongly shows in the byte read back right after completion. Flag state that is lost or wrongly set appears in the next status read.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_RX   = 2'd2
    } hdx_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    localparam int S_DONE = 0;
    localparam int S_WCOL = 1;
    localparam int S_RCOL = 2;
endpackage

// File: rtl/hdx_clkgen.sv
module hdx_clkgen #(
    parameter int RW   = 2,
    parameter int HMIN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [RW-1:0] rate,
    output logic          half_tick
);
    localparam int CW = HMIN + (1 << RW) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // half-period = 2^(HMIN+rate) clocks; ~rate = (2^RW-1) - rate
    assign last      = {CW{1'b1}} >> (~rate);
    assign half_tick = run && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (!run || half_tick) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |=> !half_tick);
endmodule

// File: rtl/hdx_engine.sv
module hdx_engine
    import hdx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          start_tx,
    input  logic          start_rx,
    input  logic [DW-1:0] tx_byte,
    input  logic          half_tick,
    input  logic          sdata_i,
    output logic          busy,
    output logic          tx_active,
    output logic          rx_active,
    output logic          done_pulse,
    output logic [DW-1:0] shreg,
    output logic          sclk_o,
    output logic          sdata_o,
    output logic          sdata_oe
);
    localparam int BCW = $clog2(DW);

    hdx_state_e     state, nstate;
    logic           phase;
    logic [BCW-1:0] bitcnt;
    logic           samp;
    logic           last_tick;

    assign last_tick = half_tick && phase && (bitcnt == BCW'(DW - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (start_tx)      nstate = ST_TX;
                else if (start_rx) nstate = ST_RX;
            end
            ST_TX, ST_RX: begin
                if (last_tick) nstate = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= 1'b0;
            bitcnt <= '0;
            samp   <= 1'b0;
            shreg  <= '0;
        end else if (state == ST_IDLE) begin
            if (start_tx || start_rx) begin
                phase  <= 1'b0;
                bitcnt <= '0;
                shreg  <= start_tx ? tx_byte : '0;
            end
        end else if (half_tick) begin
            phase <= ~phase;
            if (!phase) begin
                samp <= sdata_i;
            end else begin
                shreg  <= {shreg[DW-2:0], samp};
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end

    always_comb begin
        busy       = (state != ST_IDLE);
        tx_active  = (state == ST_TX);
        rx_active  = (state == ST_RX);
        done_pulse = busy && last_tick;
        sclk_o     = busy ? (cpol ^ cpha ^ phase) : cpol;
        sdata_o    = tx_active && shreg[DW-1];
        sdata_oe   = tx_active;
    end

    p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_tx || start_rx) |-> (state == ST_IDLE));
    p_done_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> (state == ST_IDLE));
    p_tx_bit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !half_tick) |=> $stable(sdata_o));
endmodule

// File: rtl/hdx_regs.sv
module hdx_regs
    import hdx_pkg::*;
#(
    parameter int DW = 8,
    parameter int RW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          busy,
    input  logic          tx_active,
    input  logic          rx_active,
    input  logic          done_pulse,
    input  logic [DW-1:0] rx_byte,
    output logic          cpol,
    output logic          cpha,
    output logic [RW-1:0] rate,
    output logic          start_tx,
    output logic          start_rx,
    output logic [DW-1:0] tx_byte
);
    localparam int RXB = 2 + RW;
    localparam int ENB = 3 + RW;

    logic rxgo_q, en_q;
    logic done_q, wcol_q, rcol_q, full_q;
    logic wr_ctrl, wr_data, wr_stat, rd_data;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_data = reg_wr && (reg_addr == A_DATA);
    assign wr_stat = reg_wr && (reg_addr == A_STAT);
    assign rd_data = reg_rd && (reg_addr == A_DATA);

    assign start_tx = wr_data && en_q && !busy;
    assign start_rx = rxgo_q && en_q && !busy && !full_q && !start_tx;
    assign tx_byte  = reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpol   <= 1'b0;
            cpha   <= 1'b0;
            rate   <= '0;
            en_q   <= 1'b0;
            rxgo_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                cpol <= reg_wdata[0];
                cpha <= reg_wdata[1];
                rate <= reg_wdata[2 +: RW];
                en_q <= reg_wdata[ENB];
            end
            if (done_pulse && rx_active) rxgo_q <= 1'b0;
            else if (wr_ctrl && !rx_active) rxgo_q <= reg_wdata[RXB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            wcol_q <= 1'b0;
            rcol_q <= 1'b0;
            full_q <= 1'b0;
        end else begin
            if (done_pulse)                           done_q <= 1'b1;
            else if (wr_stat && reg_wdata[S_DONE])    done_q <= 1'b0;
            if (wr_data && tx_active)                 wcol_q <= 1'b1;
            else if (wr_stat && reg_wdata[S_WCOL])    wcol_q <= 1'b0;
            if (rd_data && rx_active)                 rcol_q <= 1'b1;
            else if (wr_stat && reg_wdata[S_RCOL])    rcol_q <= 1'b0;
            if (done_pulse && rx_active)              full_q <= 1'b1;
            else if ((rd_data && !rx_active) || start_tx) full_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = DW'({en_q, rxgo_q, rate, cpha, cpol});
            A_DATA:  reg_rdata = rx_byte;
            A_STAT:  reg_rdata = DW'({full_q, busy, rcol_q, wcol_q, done_q});
            default: reg_rdata = '0;
        endcase
    end

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> done_q);
    p_rxgo_hwclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && rx_active) |=> !rxgo_q);
    p_wcol_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol_q && !(wr_stat && reg_wdata[S_WCOL])) |=> wcol_q);
    p_full_after_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && rx_active) |=> full_q);
endmodule

// File: rtl/hdx_serial_port.sv
module hdx_serial_port #(
    parameter int DW   = 8,
    parameter int RW   = 2,
    parameter int HMIN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          sclk_o,
    output logic          sdata_o,
    output logic          sdata_oe,
    input  logic          sdata_i
);
    logic          cpol, cpha;
    logic [RW-1:0] rate;
    logic          start_tx, start_rx;
    logic [DW-1:0] tx_byte, shreg;
    logic          busy, tx_active, rx_active, done_pulse, half_tick;

    hdx_regs #(.DW(DW), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .tx_active(tx_active), .rx_active(rx_active),
        .done_pulse(done_pulse), .rx_byte(shreg),
        .cpol(cpol), .cpha(cpha), .rate(rate),
        .start_tx(start_tx), .start_rx(start_rx), .tx_byte(tx_byte)
    );

    hdx_clkgen #(.RW(RW), .HMIN(HMIN)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(busy), .rate(rate),
        .half_tick(half_tick)
    );

    hdx_engine #(.DW(DW)) u_engine (
        .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha),
        .start_tx(start_tx), .start_rx(start_rx), .tx_byte(tx_byte),
        .half_tick(half_tick), .sdata_i(sdata_i),
        .busy(busy), .tx_active(tx_active), .rx_active(rx_active),
        .done_pulse(done_pulse), .shreg(shreg),
        .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe(sdata_oe)
    );

    p_oe_not_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe |-> !rx_active);
endmodule

// File: tb/hdx_serial_port_test.sv
module hdx_serial_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sclk_o, sdata_o, sdata_oe;
    logic       sdata_i = 1'b0;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    hdx_serial_port uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
        .sdata_i(sdata_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v, ctrl, tb, rb;
        int bad, half, hits;
        logic expclk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk(v == 8'h00, "R1", "ctrl after reset", v, 0);
        rd(2'd2, v); chk(v == 8'h00, "R1", "status after reset", v, 0);
        chk({sclk_o, sdata_o, sdata_oe} == 3'b000, "R1", "pins after reset",
            {sclk_o, sdata_o, sdata_oe}, 0);
        // R2 map
        wr(2'd0, 8'h0D); rd(2'd0, v); chk(v == 8'h0D, "R2", "ctrl readback", v, 8'h0D);
        rd(2'd3, v); chk(v == 8'h00, "R2", "addr 3 reads zero", v, 0);

        // sweep all modes and rates
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 4; r++) begin
                ctrl = 8'h20 | 8'(r << 2) | 8'(m);
                half = 2 << r;
                wr(2'd0, ctrl);
                wr(2'd2, 8'h07);
                chk(sclk_o == ctrl[0] && !sdata_oe, "R3", "idle clock level",
                    sclk_o, ctrl[0]);
                tb = 8'((m * 4 + r) * 29 + 8'h5A);
                rb = ~tb ^ 8'h33;
                // transmit, R3 R4 R5
                wr(2'd1, tb);
                bad = 0;
                for (int h = 0; h < 16; h++) begin
                    expclk = ctrl[0] ^ ctrl[1] ^ h[0];
                    for (int e = 0; e < 2; e++) begin
                        if (sclk_o != expclk || sdata_o != tb[7 - h/2] || !sdata_oe)
                            bad++;
                        if (e == 0) idle(half - 1);
                    end
                    idle(1);
                end
                chk(bad == 0, "R3 R4 R5", "tx waveform mismatches", bad, 0);
                chk(sclk_o == ctrl[0] && !sdata_oe && !sdata_o, "R5",
                    "lines idle after tx", {sclk_o, sdata_oe}, {ctrl[0], 1'b0});
                rd(2'd2, v); chk(v == 8'h01, "R8", "status after tx", v, 8'h01);
                wr(2'd2, 8'h01);
                // receive, R3 R4 R6
                wr(2'd0, ctrl | 8'h10);
                idle(1);
                bad = 0;
                for (int h = 0; h < 16; h++) begin
                    if (!h[0]) sdata_i = rb[7 - h/2];
                    expclk = ctrl[0] ^ ctrl[1] ^ h[0];
                    for (int e = 0; e < 2; e++) begin
                        if (sclk_o != expclk || sdata_oe || sdata_o) bad++;
                        if (e == 0) idle(half - 1);
                    end
                    idle(1);
                end
                chk(bad == 0, "R3 R4 R6", "rx waveform mismatches", bad, 0);
                rd(2'd0, v); chk(v == ctrl, "R6", "request bit cleared", v, ctrl);
                rd(2'd2, v); chk(v == 8'h11, "R8 R6", "status after rx", v, 8'h11);
                rd(2'd1, v); chk(v == rb, "R6", "received byte", v, rb);
                rd(2'd2, v); chk(v == 8'h01, "R7", "full cleared by read", v, 8'h01);
            end
        end

        // R6 pending request while buffer full
        wr(2'd0, 8'h20); wr(2'd2, 8'h07);
        sdata_i = 1'b1;
        wr(2'd0, 8'h30); idle(40);
        wr(2'd0, 8'h30);
        hits = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sclk_o != 1'b0) hits++;
        end
        chk(hits == 0, "R6", "no clock while buffer full", hits, 0);
        rd(2'd2, v); chk(v == 8'h11, "R6", "idle with full buffer", v, 8'h11);
        rd(2'd0, v); chk(v == 8'h30, "R6", "request still pending", v, 8'h30);
        rd(2'd1, v); chk(v == 8'hFF, "R6", "first byte", v, 8'hFF);
        sdata_i = 1'b0;
        idle(40);
        rd(2'd1, v); chk(v == 8'h00, "R6", "pending receive ran", v, 0);

        // R9 write collision
        wr(2'd0, 8'h2C); wr(2'd2, 8'h07);
        wr(2'd1, 8'h00);
        wr(2'd1, 8'hFF);
        hits = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (sdata_oe && sdata_o) hits++;
        end
        chk(hits == 0, "R9", "colliding write altered tx", hits, 0);
        rd(2'd2, v); chk(v == 8'h03, "R9", "status after write collision", v, 8'h03);

        // R10 read collision
        wr(2'd2, 8'h07);
        wr(2'd0, 8'h3C); idle(10);
        rd(2'd1, v); idle(300);
        rd(2'd2, v); chk(v == 8'h15, "R10", "status after read collision", v, 8'h15);

        // R12 selective clears
        wr(2'd2, 8'h04); rd(2'd2, v); chk(v == 8'h11, "R12", "clear rcol only", v, 8'h11);
        wr(2'd2, 8'h18); rd(2'd2, v); chk(v == 8'h11, "R12", "busy/full not writable", v, 8'h11);
        wr(2'd2, 8'h01); rd(2'd2, v); chk(v == 8'h10, "R12", "clear done", v, 8'h10);

        // R11 disabled port
        rd(2'd1, v);
        wr(2'd0, 8'h00); wr(2'd2, 8'h07);
        wr(2'd1, 8'hA5);
        hits = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sdata_oe || sclk_o) hits++;
        end
        chk(hits == 0, "R11", "activity while disabled", hits, 0);
        rd(2'd2, v); chk(v == 8'h00, "R11", "status while disabled", v, 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule